// File: doc/BRIEF.md
# Serial Memory Probe Sequencer

This block runs once after reset. It identifies a serial nonvolatile memory that sits on an SPI bus and derives how the rest of the chip must talk to it. It drives a simple byte shifter. For each byte it raises a start strobe together with the byte to send, waits for the shifter's completion strobe, and takes the byte received in that transfer. It also drives the memory's active-low chip select, which stays low across every byte of one transaction and goes high between transactions.

The sequence has up to three transactions. The first reads the status byte and stops the probe if the memory reports itself busy. The second reads a nine-byte identity string. The sequencer checks the vendor byte and the size code in that string and decodes the capacity from the size code. The capacity selects two-byte or three-byte addressing. When the identity string announces a serial number, a third transaction reads eight serial bytes and stores them in reversed order.

When the sequence ends, `done` pulses once with an error code. On success the capacity, address length and serial number stay on their outputs until the next reset. On error those outputs keep their reset values.

Top module: `spi_mem_probe`

## Requirements
- R1: The first transaction sends 0x05 and then one data byte. If bit 0 of the received status byte is 1, the probe ends with err = 1 and no further transaction. The other status bits are ignored.
- R2: The second transaction sends 0x9F and then reads 9 bytes (indices 0 to 8), all with chip select held low. Chip select is high for at least one cycle between any two transactions.
- R3: If identity byte 6 is not 0xC2, the probe ends with err = 2. This check takes priority over the size check.
- R4: If identity byte 7 is below 0x21 or above 0x26, the probe ends with err = 3.
- R5: On success, cap_log2 = byte7 − 0x21 + 14 and cap_bytes = 2^cap_log2. This covers 16 KiB to 512 KiB.
- R6: On success, addr_len is 3 when cap_bytes exceeds 65536 and 2 otherwise.
- R7: If identity byte 8 is nonzero, a third transaction sends 0xC3 and then reads 8 bytes. serial[7:0] holds the last byte received and serial[63:56] holds the first, and serial_ok is 1. If byte 8 is zero, no third transaction occurs, serial stays 0 and serial_ok stays 0.
- R8: `done` is high for exactly one cycle per reset. After it, no transfer is started and the outputs do not change.
- R9: At reset and after any error, err (error case excepted), cap_log2, cap_bytes, addr_len, serial and serial_ok are all 0. err codes are 0 for success, 1 for not present, 2 for wrong vendor and 3 for unsupported size.
- R10: Each start strobe lasts one cycle. A new start waits for the completion of the previous byte. Every byte after the opcode is sent as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | output | 1 | One-cycle request to shift one byte |
| xfer_tx | output | 8 | Byte to send with the request |
| xfer_done | input | 1 | One-cycle completion from the shifter |
| xfer_rx | input | 8 | Byte received, valid with xfer_done |
| cs_n | output | 1 | Memory chip select, active low |
| done | output | 1 | One-cycle end-of-probe pulse |
| err | output | 2 | Result code (0 ok, 1 not present, 2 wrong vendor, 3 size) |
| cap_log2 | output | 5 | log2 of capacity in bytes |
| cap_bytes | output | 20 | Capacity in bytes |
| addr_len | output | 2 | Address bytes to use (2 or 3) |
| serial | output | 64 | Serial number, byte-reversed |
| serial_ok | output | 1 | Serial number was read |

## Verification
The last identity byte decides whether a serial read follows. That same byte arrives in the same cycle as the vendor and size verdicts, which use bytes stored earlier. The bench provokes this collision with a nonzero serial flag combined with a bad vendor or a bad size code, and with shifter latencies as short as one cycle. It judges the result by the error code, by the opcode log (no 0xC3 may appear) and by result outputs that stay at zero. The final address-length and capacity write also coincides with the ending decision. Boundary size codes 0x23 and 0x24 check that the 64 KiB threshold is applied in that same cycle.

// File: rtl/spi_mem_probe.sv
module spi_mem_probe #(
  parameter int ID_BYTES = 9,
  parameter int SN_BYTES = 8,
  parameter logic [7:0] VENDOR = 8'hC2,
  parameter logic [7:0] SIZE_MIN = 8'h21,
  parameter logic [7:0] SIZE_MAX = 8'h26,
  parameter int BASE_LOG2 = 14,
  parameter int ADDR3_LOG2 = 16,
  parameter int CAP_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  xfer_start,
  output logic [7:0]            xfer_tx,
  input  logic                  xfer_done,
  input  logic [7:0]            xfer_rx,
  output logic                  cs_n,
  output logic                  done,
  output logic [1:0]            err,
  output logic [$clog2(CAP_W)-1:0] cap_log2,
  output logic [CAP_W-1:0]      cap_bytes,
  output logic [1:0]            addr_len,
  output logic [8*SN_BYTES-1:0] serial,
  output logic                  serial_ok
);
  localparam int CW = $clog2(ID_BYTES + 2);
  localparam int LW = $clog2(CAP_W);
  localparam logic [1:0] PH_SR = 2'd0, PH_ID = 2'd1, PH_SN = 2'd2;
  localparam logic [1:0] E_ABSENT = 2'd1, E_VENDOR = 2'd2, E_SIZE = 2'd3;

  typedef enum logic [2:0] {S_BOOT, S_SEND, S_WAIT, S_GAP, S_FIN, S_HALT} st_t;

  st_t st;
  logic [1:0] ph;
  logic [CW-1:0] cnt, last;
  logic [7:0] vid, szc, opcode;

  always_comb begin
    case (ph)
      PH_SR:   begin last = CW'(1);        opcode = 8'h05; end
      PH_ID:   begin last = CW'(ID_BYTES); opcode = 8'h9F; end
      default: begin last = CW'(SN_BYTES); opcode = 8'hC3; end
    endcase
  end

  wire size_ok = (szc >= SIZE_MIN) && (szc <= SIZE_MAX);
  wire [7:0] sz_ofs = szc - SIZE_MIN;
  wire [LW-1:0] lg = LW'(sz_ofs) + LW'(BASE_LOG2);

  assign xfer_start = (st == S_SEND);
  assign xfer_tx    = (cnt == '0) ? opcode : 8'h00;
  assign cs_n       = !((st == S_SEND) || (st == S_WAIT));
  assign done       = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_BOOT;
      ph <= PH_SR;
      cnt <= '0;
      vid <= '0;
      szc <= '0;
      err <= '0;
      cap_log2 <= '0;
      cap_bytes <= '0;
      addr_len <= '0;
      serial <= '0;
      serial_ok <= 1'b0;
    end else begin
      case (st)
        S_BOOT: st <= S_SEND;
        S_SEND: st <= S_WAIT;
        S_WAIT: if (xfer_done) begin
          cnt <= cnt + 1'b1;
          st <= S_SEND;
          if (ph == PH_ID && cnt == CW'(ID_BYTES - 2)) vid <= xfer_rx;
          if (ph == PH_ID && cnt == CW'(ID_BYTES - 1)) szc <= xfer_rx;
          if (ph == PH_SN && cnt != '0) serial <= {serial[8*SN_BYTES-9:0], xfer_rx};
          if (cnt == last) begin
            cnt <= '0;
            st <= S_GAP;
            case (ph)
              PH_SR:
                if (xfer_rx[0]) begin err <= E_ABSENT; st <= S_FIN; end
                else ph <= PH_ID;
              PH_ID:
                if (vid != VENDOR) begin err <= E_VENDOR; st <= S_FIN; end
                else if (!size_ok) begin err <= E_SIZE; st <= S_FIN; end
                else begin
                  cap_log2 <= lg;
                  cap_bytes <= CAP_W'(1) << lg;
                  addr_len <= (lg > LW'(ADDR3_LOG2)) ? 2'd3 : 2'd2;
                  if (xfer_rx != 8'h00) ph <= PH_SN;
                  else st <= S_FIN;
                end
              default: begin serial_ok <= 1'b1; st <= S_FIN; end
            endcase
          end
        end
        S_GAP:  st <= S_SEND;
        S_FIN:  st <= S_HALT;
        default: st <= S_HALT;
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_frozen_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> (!xfer_start && $stable(cap_bytes) && $stable(serial) && $stable(err)));
  p_err_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err != 2'd0) |-> (cap_bytes == '0 && addr_len == 2'd0 && serial == '0 && !serial_ok));
  p_addr_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == 2'd0) |-> (addr_len == ((cap_bytes > (CAP_W'(1) << ADDR3_LOG2)) ? 2'd3 : 2'd2)));
  p_cap_pow2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == 2'd0) |-> ($countones(cap_bytes) == 1));
  p_single_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  p_start_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !cs_n);
  p_busy_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && ph == PH_SR && cnt == CW'(1) && xfer_done && xfer_rx[0]) |=> (done && err == E_ABSENT));
endmodule

// File: tb/tb_spi_mem_probe.sv
`timescale 1ns/1ps
module tb_spi_mem_probe;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xfer_start, xfer_done = 1'b0, cs_n, done, serial_ok;
  logic [7:0] xfer_tx, xfer_rx = 8'h00;
  logic [1:0] err, addr_len;
  logic [4:0] cap_log2;
  logic [19:0] cap_bytes;
  logic [63:0] serial;

  spi_mem_probe dut (.clk, .rst_n, .xfer_start, .xfer_tx, .xfer_done, .xfer_rx,
    .cs_n, .done, .err, .cap_log2, .cap_bytes, .addr_len, .serial, .serial_ok);

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  logic [7:0] st_byte, id_b [0:8];
  logic [63:0] sn_val;
  logic [7:0] ops [0:3];
  int tlen [0:3];
  int nops, ndone, bad_tx, bidx, wait_n;
  logic pend;
  logic [7:0] cur_op, resp;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_err(input logic [7:0] s, input logic [7:0] v, input logic [7:0] z);
    if (s[0]) return 2'd1;
    if (v != 8'hC2) return 2'd2;
    if (z < 8'h21 || z > 8'h26) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [63:0] exp_serial(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
    return r;
  endfunction

  // memory and shifter model
  initial begin
    pend = 0; bidx = 0; nops = 0; ndone = 0; bad_tx = 0; wait_n = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pend = 0; bidx = 0; xfer_done = 0;
      end else begin
        xfer_done = 0;
        if (done) ndone++;
        if (cs_n && !pend) bidx = 0;
        if (pend) begin
          if (wait_n == 0) begin xfer_done = 1; xfer_rx = resp; pend = 0; end
          else wait_n--;
        end else if (xfer_start) begin
          if (cs_n) bad_tx++;
          if (bidx == 0) begin
            cur_op = xfer_tx;
            if (nops < 4) ops[nops] = xfer_tx;
            nops++;
            resp = 8'hFF;
          end else begin
            if (xfer_tx != 8'h00) bad_tx++;
            if (cur_op == 8'h05) resp = st_byte;
            else if (cur_op == 8'h9F && bidx <= 9) resp = id_b[bidx-1];
            else if (cur_op == 8'hC3 && bidx <= 8) resp = sn_val[8*(bidx-1) +: 8];
            else resp = 8'hFF;
          end
          if (nops >= 1 && nops <= 4) tlen[nops-1] = bidx + 1;
          bidx++;
          pend = 1;
          wait_n = $urandom_range(0, 2);
        end
      end
    end
  end

  task automatic run(input logic [7:0] s, input logic [7:0] v, input logic [7:0] z,
                     input logic [7:0] fl, input logic [63:0] snv);
    logic [1:0] ee;
    int en, t, nops_at;
    logic [4:0] el;
    st_byte = s; id_b[6] = v; id_b[7] = z; id_b[8] = fl; sn_val = snv;
    for (int k = 0; k < 6; k++) id_b[k] = 8'($urandom);
    rst_n = 0;
    repeat (3) @(negedge clk);
    nops = 0; ndone = 0; bad_tx = 0;
    for (int k = 0; k < 4; k++) begin ops[k] = 8'h00; tlen[k] = 0; end
    chk(!done && err == 0 && cap_bytes == 0 && addr_len == 0 && serial == 0 && !serial_ok && cs_n,
        "R9 reset state", {done, err, addr_len, serial_ok, cs_n}, 64'h1);
    rst_n = 1;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done, "R8 done reached", done, 1);
    ee = exp_err(s, v, z);
    chk(err == ee, "R1 R3 R4 error code", err, ee);
    chk(nops >= 1 && ops[0] == 8'h05 && tlen[0] == 2, "R1 status transaction", {ops[0], 24'(tlen[0])}, 64'h05000002);
    en = (ee == 2'd1) ? 1 : (ee != 2'd0 || fl == 8'h00) ? 2 : 3;
    chk(nops == en, "R2 R7 transaction count", nops, en);
    if (en >= 2) chk(ops[1] == 8'h9F && tlen[1] == 10, "R2 identity transaction", {ops[1], 24'(tlen[1])}, 64'h9F00000A);
    if (en == 3) chk(ops[2] == 8'hC3 && tlen[2] == 9, "R7 serial transaction", {ops[2], 24'(tlen[2])}, 64'hC3000009);
    chk(bad_tx == 0, "R10 data bytes zero under select", bad_tx, 0);
    if (ee == 2'd0) begin
      el = 5'(z - 8'h21 + 8'd14);
      chk(cap_log2 == el, "R5 cap_log2", cap_log2, el);
      chk(cap_bytes == (20'd1 << el), "R5 cap_bytes", cap_bytes, 20'd1 << el);
      chk(addr_len == ((el > 5'd16) ? 2'd3 : 2'd2), "R6 addr_len", addr_len, (el > 5'd16) ? 3 : 2);
      chk(serial_ok == (fl != 8'h00), "R7 serial_ok", serial_ok, fl != 8'h00);
      chk(serial == ((fl != 8'h00) ? exp_serial(snv) : 64'h0), "R7 serial order", serial,
          (fl != 8'h00) ? exp_serial(snv) : 64'h0);
    end else begin
      chk(cap_log2 == 0 && cap_bytes == 0 && addr_len == 0 && serial == 0 && !serial_ok,
          "R9 results clean on error", {cap_bytes, addr_len, serial_ok}, 0);
    end
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    nops_at = nops;
    repeat (30) @(negedge clk);
    chk(nops == nops_at && ndone == 1 && cs_n, "R8 quiet after done", {32'(nops), 32'(ndone)},
        {32'(nops_at), 32'd1});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] rs, rv, rz, rf;
    void'($urandom(32'd2024));
    run(8'h01, 8'hC2, 8'h24, 8'h01, 64'h1122334455667788); // R1 busy
    run(8'h8C, 8'hC2, 8'h21, 8'h00, 64'h0);                // R1 other bits ignored, R5 16 KiB
    run(8'h00, 8'hC1, 8'h24, 8'h05, 64'hDEADBEEF00112233); // R3 wrong vendor, flag set
    run(8'h00, 8'hC3, 8'h30, 8'h00, 64'h0);                // R3 priority over R4
    run(8'h00, 8'hC2, 8'h20, 8'h01, 64'h0123456789ABCDEF); // R4 low bound
    run(8'h00, 8'hC2, 8'h27, 8'h01, 64'h0123456789ABCDEF); // R4 high bound
    run(8'h00, 8'hC2, 8'h23, 8'h00, 64'h0);                // R6 64 KiB -> 2
    run(8'h00, 8'hC2, 8'h24, 8'h80, 64'h0807060504030201); // R6 128 KiB -> 3, R7
    run(8'h00, 8'hC2, 8'h26, 8'hFF, 64'hA5A55A5AC3C33C3C); // R5 512 KiB
    for (int n = 0; n < 24; n++) begin
      rs = 8'($urandom) & 8'hFE;
      if ($urandom_range(0, 5) == 0) rs[0] = 1'b1;
      rv = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'hC2;
      rz = 8'h1F + 8'($urandom_range(0, 8));
      rf = ($urandom_range(0, 1) == 0) ? 8'h00 : (8'($urandom) | 8'h01);
      run(rs, rv, rz, rf, {32'($urandom), 32'($urandom)});
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule